// File: doc/BRIEF.md
# Cascadable Signed Multiply-Accumulate Slice

This block multiplies two signed 28-bit operands and then adds the full 56-bit product to, or subtracts it from, an accumulator operand. The accumulator operand comes from one of two places, chosen when the slice is instantiated: the slice's own registered result, which gives local accumulation, or a 56-bit cascade input driven by a neighbouring slice. A mask input forces the accumulator operand to zero, so a new sum can start from the product alone. The slice also reports the carry out of the top result bit.

Every pipeline register can be removed by a parameter. This covers each of the four input registers (operand A, operand B, the subtract control and the mask), the multiplier register, and the output register that holds the result and the carry. The output register has its own synchronous active-low clear. A parameter decides whether that clear needs the output clock enable. A cascade output forwards either the final result or the multiplier-stage value to the next slice in a chain.

Two parameter combinations are refused at elaboration. The result and carry registers must be both kept or both removed. Feedback accumulation needs the output register, because without it the feedback path would be a combinational loop. For this reason the output register is kept by default.

Top module: `mac_slice`

## Requirements
- R1: The product is the full signed two's-complement product of the 28-bit operands A and B, 56 bits wide with nothing truncated, and the result is taken modulo 2^56.
- R2: When the subtract control is 1, the result is the accumulator operand minus the product. When it is 0, the result is the accumulator operand plus the product.
- R3: When the mask is 1, the accumulator operand is zero, so the result is plus or minus the product.
- R4: The carry output is bit 56 of the 57-bit unsigned sum of the accumulator operand, the product (inverted when subtracting) and the subtract bit.
- R5: With ACC_SRC = 0, the accumulator operand is the current registered result, so successive products accumulate.
- R6: With ACC_SRC = 1, the accumulator operand is cas_i, sampled in the cycle in which the output register loads.
- R7: With CAS_SRC = 0, cas_o equals dout_o. With CAS_SRC = 1, cas_o is the multiplier-stage value, taken after its optional register.
- R8: With RST_PRIO = PRIO_CE (the default), a low out_rst_n clears dout_o and carry_o at the next rising edge only when ce_out is 1. When ce_out is 0, the output holds. In the same cycle, the clear wins over a load.
- R9: With RST_PRIO = PRIO_RST, a low out_rst_n clears dout_o and carry_o at the next rising edge whatever the value of ce_out.
- R10: When ce_out is 0 and out_rst_n is 1, dout_o and carry_o hold their values.
- R11: Each input register and the multiplier register delays its signal by one cycle when its parameter is 1. A stage whose clock enable is 0 holds its value. The subtract and mask controls travel through the multiplier register alongside the product.
- R12: A low rst_n clears every register in the slice to zero at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low clear of all registers |
| a_i | input | 28 | Signed operand A |
| b_i | input | 28 | Signed operand B |
| sub_i | input | 1 | 1 = subtract product, 0 = add product |
| mask_i | input | 1 | 1 = accumulator operand forced to zero |
| ce_a | input | 1 | Clock enable, operand A register |
| ce_b | input | 1 | Clock enable, operand B register |
| ce_sub | input | 1 | Clock enable, subtract-control register |
| ce_mask | input | 1 | Clock enable, mask register |
| ce_mul | input | 1 | Clock enable, multiplier register |
| ce_out | input | 1 | Clock enable, result and carry register |
| out_rst_n | input | 1 | Synchronous active-low clear of result and carry |
| cas_i | input | 56 | Cascade accumulator operand from a neighbour |
| dout_o | output | 56 | Result |
| carry_o | output | 1 | Carry out of result bit 55 |
| cas_o | output | 56 | Cascade output to the next slice |

## Verification
The output clear and a new accumulation can fall in the same cycle. The bench provokes this by holding out_rst_n low while ce_out is high and a non-zero product is waiting to be loaded. It then checks that the result reads zero and not the new sum. It also checks the opposite case: with the clock enable low, the default mode ignores the clear, while the reset-priority instance clears anyway. Both decisions are judged at the ports one cycle after the edge.

// File: rtl/mac_pkg.sv
// Shared types for the multiply-accumulate slice.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package mac_pkg;

    // Decides whether the output clear needs the output clock enable.
    typedef enum logic {
        PRIO_CE  = 1'b0,
        PRIO_RST = 1'b1
    } rst_prio_e;

    // Control bits that travel with the product down the pipeline.
    typedef struct packed {
        logic sub;
        logic mask;
    } ctrl_t;

endpackage

// File: rtl/mac_stage.sv
// Pipeline stage that can be removed by a parameter.
// USE=1: a register with a clock enable and a synchronous active-low clear.
// USE=0: a plain wire; the clock, clear and enable are then unused.
// Assumes: rst_n is synchronous to clk.
module mac_stage #(
    parameter int W   = 8,
    parameter bit USE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (USE) begin : g_reg
            logic [W-1:0] r;

            // Load the stage when enabled; clear it on reset.
            always_ff @(posedge clk) begin
                if (!rst_n)  r <= '0;
                else if (ce) r <= d;
            end

            assign q = r;

            AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !ce |=> $stable(q)); // R11
        end else begin : g_byp
            logic unused_ctl;

            assign q          = d;
            assign unused_ctl = ^{clk, rst_n, ce};
        end
    endgenerate

endmodule

// File: rtl/mac_addsub.sv
// Adder/subtractor for the slice.
// It computes acc + prod, or acc - prod, as acc + ~prod + 1.
// The carry is bit W of the unsigned (W+1)-bit sum.
// Assumes: operands are already aligned to the same pipeline stage.
module mac_addsub #(
    parameter int W = 56
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] prod,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry
);

    logic [W:0] wide;

    // Compute the one wide sum that carries both the result and the carry.
    always_comb begin
        wide = {1'b0, acc} + {1'b0, (sub ? ~prod : prod)} + {{W{1'b0}}, sub};
    end

    assign sum   = wide[W-1:0];
    assign carry = wide[W];

endmodule

// File: rtl/mac_outreg.sv
// Result and carry register, which can be removed by a parameter.
// It has a dedicated synchronous active-low clear.
// PRIO selects whether that clear needs ce (PRIO_CE) or overrides it (PRIO_RST).
// Assumes: rst_n and clr_n are synchronous to clk.
module mac_outreg
    import mac_pkg::*;
#(
    parameter int        W    = 57,
    parameter bit        USE  = 1'b1,
    parameter rst_prio_e PRIO = PRIO_CE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (USE) begin : g_reg
            logic [W-1:0] r;
            logic         clr_go;

            // Decide whether the dedicated clear acts in this cycle.
            assign clr_go = !clr_n && ((PRIO == PRIO_RST) || ce);

            // Clear on either reset, otherwise load when enabled.
            always_ff @(posedge clk) begin
                if (!rst_n)      r <= '0;
                else if (clr_go) r <= '0;
                else if (ce)     r <= d;
            end

            assign q = r;

            AST_CLR_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_n && ce) |=> (q == '0)); // R8
            AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_n && !ce) |=> $stable(q)); // R10

            if (PRIO == PRIO_RST) begin : g_prio_rst
                AST_CLR_WITHOUT_CE: assert property (@(posedge clk) disable iff (!rst_n)
                    !clr_n |=> (q == '0)); // R9
            end else begin : g_prio_ce
                AST_CLR_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
                    (!clr_n && !ce) |=> $stable(q)); // R8
            end
        end else begin : g_byp
            logic unused_ctl;

            assign q          = d;
            assign unused_ctl = ^{clk, rst_n, clr_n, ce};
        end
    endgenerate

endmodule

// File: rtl/mac_slice.sv
// Cascadable signed multiply-accumulate slice.
// Data path: input stages -> signed multiply -> multiplier stage -> add/sub
// with a selectable accumulator operand -> result/carry stage.
// The sub and mask controls ride through the multiplier stage with the product.
// Assumes: feedback mode (ACC_SRC=0) requires REG_OUT=1, and REG_OUT equals
// REG_CARRY; both rules are enforced at elaboration.
module mac_slice
    import mac_pkg::*;
#(
    parameter int        A_W       = 28,
    parameter int        B_W       = 28,
    parameter bit        REG_A     = 1'b0,
    parameter bit        REG_B     = 1'b0,
    parameter bit        REG_SUB   = 1'b0,
    parameter bit        REG_MASK  = 1'b0,
    parameter bit        REG_MUL   = 1'b0,
    parameter bit        REG_OUT   = 1'b1,
    parameter bit        REG_CARRY = 1'b1,
    parameter bit        ACC_SRC   = 1'b0,
    parameter bit        CAS_SRC   = 1'b0,
    parameter rst_prio_e RST_PRIO  = PRIO_CE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [A_W-1:0]       a_i,
    input  logic [B_W-1:0]       b_i,
    input  logic                 sub_i,
    input  logic                 mask_i,
    input  logic                 ce_a,
    input  logic                 ce_b,
    input  logic                 ce_sub,
    input  logic                 ce_mask,
    input  logic                 ce_mul,
    input  logic                 ce_out,
    input  logic                 out_rst_n,
    input  logic [A_W+B_W-1:0]   cas_i,
    output logic [A_W+B_W-1:0]   dout_o,
    output logic                 carry_o,
    output logic [A_W+B_W-1:0]   cas_o
);

    localparam int P_W  = A_W + B_W;
    localparam int MS_W = P_W + $bits(ctrl_t);

    // Elaboration-time legality checks.
    generate
        if (REG_OUT != REG_CARRY) begin : g_bad_carry_cfg
            $error("mac_slice: REG_OUT and REG_CARRY must match");
        end
        if (!ACC_SRC && !REG_OUT) begin : g_bad_loop_cfg
            $error("mac_slice: feedback accumulation needs REG_OUT=1");
        end
    endgenerate

    logic [A_W-1:0]  a_q;
    logic [B_W-1:0]  b_q;
    ctrl_t           ctl_q;
    ctrl_t           ctl_m;
    logic [P_W-1:0]  prod_c;
    logic [P_W-1:0]  prod_m;
    logic [P_W-1:0]  acc_raw;
    logic [P_W-1:0]  acc_op;
    logic [P_W-1:0]  sum;
    logic            cy;

    mac_stage #(.W(A_W), .USE(REG_A)) u_stg_a (
        .clk(clk), .rst_n(rst_n), .ce(ce_a), .d(a_i), .q(a_q));
    mac_stage #(.W(B_W), .USE(REG_B)) u_stg_b (
        .clk(clk), .rst_n(rst_n), .ce(ce_b), .d(b_i), .q(b_q));
    mac_stage #(.W(1), .USE(REG_SUB)) u_stg_sub (
        .clk(clk), .rst_n(rst_n), .ce(ce_sub), .d(sub_i), .q(ctl_q.sub));
    mac_stage #(.W(1), .USE(REG_MASK)) u_stg_mask (
        .clk(clk), .rst_n(rst_n), .ce(ce_mask), .d(mask_i), .q(ctl_q.mask));

    // Full-width signed product, sign-extended before the multiply.
    always_comb begin
        prod_c = P_W'($signed(a_q)) * P_W'($signed(b_q));
    end

    mac_stage #(.W(MS_W), .USE(REG_MUL)) u_stg_mul (
        .clk(clk), .rst_n(rst_n), .ce(ce_mul),
        .d({prod_c, ctl_q}), .q({prod_m, ctl_m}));

    // Choose where the accumulator operand comes from.
    generate
        if (ACC_SRC) begin : g_acc_cas
            assign acc_raw = cas_i;
        end else begin : g_acc_fb
            logic unused_cas;

            assign acc_raw    = dout_o;
            assign unused_cas = ^cas_i;
        end
    endgenerate

    // Apply the mask to the accumulator operand.
    always_comb begin
        acc_op = ctl_m.mask ? '0 : acc_raw;
    end

    mac_addsub #(.W(P_W)) u_addsub (
        .acc(acc_op), .prod(prod_m), .sub(ctl_m.sub), .sum(sum), .carry(cy));

    mac_outreg #(.W(P_W + 1), .USE(REG_OUT), .PRIO(RST_PRIO)) u_out (
        .clk(clk), .rst_n(rst_n), .clr_n(out_rst_n), .ce(ce_out),
        .d({cy, sum}), .q({carry_o, dout_o}));

    // Choose what the cascade output forwards.
    generate
        if (CAS_SRC) begin : g_cas_mul
            assign cas_o = prod_m;
        end else begin : g_cas_res
            assign cas_o = dout_o;
        end
    endgenerate

    AST_MASK_PROD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_m.mask && (prod_m == '0)) |-> ((sum == '0) && (cy == ctl_m.sub))); // R3

endmodule

// File: tb/test_mac_slice.sv
`timescale 1ns/1ps
module test_mac_slice;
    import mac_pkg::*;

    localparam int  P_W  = 56;
    localparam time HALF = 2ns;

    typedef struct packed {
        logic [27:0]    a;
        logic [27:0]    b;
        logic           sub;
        logic           mask;
        logic [P_W-1:0] dout;
        logic           carry;
    } vec_t;

    // Feedback sequence: each row loads on one edge; expected result and carry.
    localparam vec_t VECS [8] = '{
        '{28'sd3,        28'sd4,        1'b0, 1'b1, 56'sd12,             1'b0},
        '{-28'sd2,       28'sd5,        1'b0, 1'b0, 56'sd2,              1'b1},
        '{28'sd7,        28'sd7,        1'b1, 1'b0, -56'sd47,            1'b0},
        '{28'sd100,      -28'sd3,       1'b1, 1'b0, 56'sd253,            1'b1},
        '{28'h8000000,   28'h8000000,   1'b0, 1'b1, 56'h40000000000000,  1'b0},
        '{28'h7FFFFFF,   28'h8000000,   1'b0, 1'b0, 56'd134217728,       1'b1},
        '{28'sd0,        28'sd123,      1'b1, 1'b0, 56'd134217728,       1'b1},
        '{28'sd5,        28'sd5,        1'b1, 1'b1, -56'sd25,            1'b0}
    };

    logic clk = 1'b0;
    logic rst_n;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // Instance 1: inputs bypassed, feedback, result cascaded, clear needs ce.
    logic [27:0]    a1, b1;
    logic           sub1, mask1, ce1, clr1_n;
    logic [P_W-1:0] dout1, cas1;
    logic           cy1;

    // Instance 2: all stages registered, cascade input, product cascaded, clear overrides ce.
    logic [27:0]    a2, b2;
    logic           sub2, mask2, ce2_ab, ce2, clr2_n;
    logic [P_W-1:0] casin2, dout2, cas2;
    logic           cy2;

    always #HALF clk = ~clk;

    mac_slice i_mac_slice (
        .clk(clk), .rst_n(rst_n), .a_i(a1), .b_i(b1), .sub_i(sub1), .mask_i(mask1),
        .ce_a(1'b1), .ce_b(1'b1), .ce_sub(1'b1), .ce_mask(1'b1), .ce_mul(1'b1),
        .ce_out(ce1), .out_rst_n(clr1_n), .cas_i('0),
        .dout_o(dout1), .carry_o(cy1), .cas_o(cas1));

    mac_slice #(
        .REG_A(1'b1), .REG_B(1'b1), .REG_SUB(1'b1), .REG_MASK(1'b1), .REG_MUL(1'b1),
        .ACC_SRC(1'b1), .CAS_SRC(1'b1), .RST_PRIO(PRIO_RST)
    ) i_mac_slice_b (
        .clk(clk), .rst_n(rst_n), .a_i(a2), .b_i(b2), .sub_i(sub2), .mask_i(mask2),
        .ce_a(ce2_ab), .ce_b(ce2_ab), .ce_sub(ce2), .ce_mask(ce2), .ce_mul(ce2),
        .ce_out(ce2), .out_rst_n(clr2_n), .cas_i(casin2),
        .dout_o(dout2), .carry_o(cy2), .cas_o(cas2));

    task automatic chk(input string req, input logic [P_W-1:0] act, input logic [P_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        a1 = '0; b1 = '0; sub1 = 1'b0; mask1 = 1'b0; ce1 = 1'b1; clr1_n = 1'b1;
        a2 = '0; b2 = '0; sub2 = 1'b0; mask2 = 1'b0; ce2 = 1'b1; ce2_ab = 1'b1;
        clr2_n = 1'b1; casin2 = '0;
        step(3);
        chk("R12 reset dout", dout1, '0);
        chk("R12 reset carry", {55'd0, cy1}, '0);
        chk("R12 reset dout b", dout2, '0);
        chk("R12 reset cas b", cas2, '0);
        rst_n = 1'b1;

        // Vector walk: R1, R2, R3, R4, R5, R7 on instance 1.
        for (int k = 0; k < 8; k++) begin
            a1 = VECS[k].a; b1 = VECS[k].b; sub1 = VECS[k].sub; mask1 = VECS[k].mask;
            step(1);
            chk($sformatf("R1 R2 R3 R5 vec %0d dout", k), dout1, VECS[k].dout);
            chk($sformatf("R4 vec %0d carry", k), {55'd0, cy1}, {55'd0, VECS[k].carry});
            chk($sformatf("R7 vec %0d cas", k), cas1, VECS[k].dout);
        end

        // R10: enable low, no clear: hold.
        a1 = 28'sd1; b1 = 28'sd1; sub1 = 1'b0; mask1 = 1'b0; ce1 = 1'b0;
        step(1);
        chk("R10 hold", dout1, -56'sd25);
        // R8: clear without enable is ignored in the default mode.
        clr1_n = 1'b0;
        step(1);
        chk("R8 clear ignored without ce", dout1, -56'sd25);
        // R8: clear and load in the same cycle; clear wins.
        ce1 = 1'b1;
        step(1);
        chk("R8 clear beats load", dout1, '0);
        chk("R8 clear carry", {55'd0, cy1}, '0);
        clr1_n = 1'b1;
        step(1);
        chk("R5 accumulate after clear", dout1, 56'sd1);

        // Instance 2: latency through the registered stages (R11, R6, R7).
        a2 = 28'sd6; b2 = -28'sd7; sub2 = 1'b1; mask2 = 1'b0; casin2 = 56'sd1000;
        step(1);
        chk("R6 cascade acc edge1", dout2, 56'sd1000);
        chk("R11 mul reg empty edge1", cas2, '0);
        step(1);
        chk("R7 cas product edge2", cas2, -56'sd42);
        chk("R11 result lags edge2", dout2, 56'sd1000);
        step(1);
        chk("R6 R2 result edge3", dout2, 56'sd1042);
        chk("R4 carry edge3", {55'd0, cy2}, '0);
        // R11: operand stages held by their enables.
        ce2_ab = 1'b0; a2 = 28'sd1; b2 = 28'sd1;
        step(3);
        chk("R11 operand hold", dout2, 56'sd1042);
        // R3: mask through registered control stages.
        mask2 = 1'b1;
        step(3);
        chk("R3 mask on cascade", dout2, 56'sd42);
        // R9: clear overrides a low enable.
        ce2 = 1'b0; clr2_n = 1'b0;
        step(1);
        chk("R9 clear without ce", dout2, '0);
        chk("R9 carry clear", {55'd0, cy2}, '0);
        clr2_n = 1'b1; ce2 = 1'b1; ce2_ab = 1'b1;
        step(2);
        // R12: global reset mid-run clears every stage.
        rst_n = 1'b0;
        step(1);
        chk("R12 mid-run cas", cas2, '0);
        chk("R12 mid-run dout", dout2, '0);
        chk("R12 mid-run dout a", dout1, '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(HALF * 2 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule